// File: doc/BRIEF.md
# Mesh Dimension-Order Route Unit

This unit computes the route for one router in a two-dimensional k-ary mesh without wraparound. The router supplies its own column and row. A header carrying the destination column and row arrives on a valid/ready handshake. The unit subtracts the local coordinate from the destination in each dimension. From the signs of the two offsets it picks one output direction: east (+X), west (-X), north (+Y), south (-Y), or eject to the local node.

Routing is strictly X first, then Y. The packet moves along the row until the column offset is zero, then makes its single turn into the column. Each hop carries a channel number, and the numbering rises along every legal route, so deadlock freedom can be checked hop by hop. For each hop the unit also reports the coordinate of the next node, so that the next router can be driven directly. The result is held in a one-entry output register until the downstream side takes it.

Top module: `mdor_route_unit`

## Requirements
- R1: During reset and in the first cycle after it, `rt_valid` is 0 and `hdr_ready` is 1.
- R2: A header accepted on a clock edge appears at the output after that same edge. `rt_off_x` is `hdr_dst_x - node_x` and `rt_off_y` is `hdr_dst_y - node_y`, both as signed values. The destination is forwarded unchanged on `rt_dst_x` and `rt_dst_y`.
- R3: When the X offset is nonzero, `rt_port` is 1 (+X) for a positive offset and 2 (-X) for a negative one, whatever the Y offset is.
- R4: When the X offset is zero, `rt_port` is 3 (+Y) for a positive Y offset and 4 (-Y) for a negative one.
- R5: When both offsets are zero, `rt_port` is 0 (eject) and `rt_chan` is 2K.
- R6: The channel number is `node_x` for a +X hop and K-1-`node_x` for a -X hop, so every X channel is below K.
- R7: The channel number is K+`node_y` for a +Y hop and 2K-1-`node_y` for a -Y hop, so every Y channel lies from K to 2K-1.
- R8: `rt_next_x` and `rt_next_y` give the neighbour reached by the chosen hop: one step in the chosen direction and dimension, the other coordinate unchanged. For eject they equal the local coordinate.
- R9: `hdr_ready` equals `!rt_valid || rt_ready`. While `rt_valid` is 1 and `rt_ready` is 0, all outputs hold.
- R10: Following the hops from any source to any destination gives strictly increasing channel numbers. The route takes |dx|+|dy| hops before the eject.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| node_x | input | CW | Column of this router |
| node_y | input | CW | Row of this router |
| hdr_valid | input | 1 | Header offered |
| hdr_ready | output | 1 | Header can be taken this cycle |
| hdr_dst_x | input | CW | Destination column |
| hdr_dst_y | input | CW | Destination row |
| rt_valid | output | 1 | Route result held |
| rt_ready | input | 1 | Downstream takes the result |
| rt_port | output | 3 | 0 eject, 1 +X, 2 -X, 3 +Y, 4 -Y |
| rt_chan | output | CHW | Deadlock-ordering channel number |
| rt_off_x | output | CW+1 | Signed column offset |
| rt_off_y | output | CW+1 | Signed row offset |
| rt_next_x | output | CW | Column of the next node |
| rt_next_y | output | CW | Row of the next node |
| rt_dst_x | output | CW | Forwarded destination column |
| rt_dst_y | output | CW | Forwarded destination row |

CW is the width of a coordinate, log2 of K rounded up. CHW is wide enough to hold 2K.

## Verification
`hdr_ready` is combinational, so the bench checks it in the same cycle the inputs are driven. Every routed field appears one clock edge after the header is accepted and stays there while the output is stalled. A behavioural model in the bench predicts the output register's next contents from the inputs driven before each edge. The bench compares at the following falling edge, so each result is checked exactly one register stage after its stimulus. Route walks feed every reported next coordinate back as the local coordinate. This checks the channel ordering and the hop count across whole paths.

// File: rtl/mdor_pkg.sv
// Package: shared encodings of the dimension-order route unit.
// Assumes the output port code is read by the neighbouring crossbar, so the
// numeric values are fixed.
package mdor_pkg;

    typedef enum logic [2:0] {
        PORT_EJECT = 3'd0,
        PORT_XPOS  = 3'd1,
        PORT_XNEG  = 3'd2,
        PORT_YPOS  = 3'd3,
        PORT_YNEG  = 3'd4
    } port_e;

endpackage

// File: rtl/mdor_offset.sv
// Module: per-dimension relative offset, destination minus current.
// Assumes both coordinates lie in 0..K-1, so one extra bit holds the signed
// difference without overflow.
module mdor_offset #(
    parameter int K    = 8,
    parameter int DIMS = 2,
    localparam int CW  = (K > 1) ? $clog2(K) : 1
) (
    input  logic [DIMS-1:0][CW-1:0] cur,
    input  logic [DIMS-1:0][CW-1:0] dst,
    output logic [DIMS-1:0][CW:0]   off
);

    for (genvar d = 0; d < DIMS; d++) begin : g_dim
        // Two's-complement difference in one dimension
        assign off[d] = {1'b0, dst[d]} - {1'b0, cur[d]};
    end

endmodule

// File: rtl/mdor_decide.sv
// Module: port choice, channel number and next-hop coordinate.
// Assumes offsets come from mdor_offset. X is resolved before Y. Channel
// bands are X in 0..K-1, Y in K..2K-1, and eject is 2K.
module mdor_decide
    import mdor_pkg::*;
#(
    parameter int K    = 8,
    localparam int CW  = (K > 1) ? $clog2(K) : 1,
    localparam int CHW = $clog2(2 * K + 1)
) (
    input  logic [CW-1:0]  cur_x,
    input  logic [CW-1:0]  cur_y,
    input  logic [CW:0]    off_x,
    input  logic [CW:0]    off_y,
    output port_e          port,
    output logic [CHW-1:0] chan,
    output logic [CW-1:0]  nxt_x,
    output logic [CW-1:0]  nxt_y
);

    localparam logic [CHW-1:0] X_TOP  = CHW'(K - 1);
    localparam logic [CHW-1:0] Y_BASE = CHW'(K);
    localparam logic [CHW-1:0] Y_TOP  = CHW'(2 * K - 1);
    localparam logic [CHW-1:0] EJ_CH  = CHW'(2 * K);

    logic [CHW-1:0] cx_w;
    logic [CHW-1:0] cy_w;

    assign cx_w = CHW'(cur_x);
    assign cy_w = CHW'(cur_y);

    // Select direction, number the channel and step the coordinate
    always_comb begin
        port  = PORT_EJECT;
        chan  = EJ_CH;
        nxt_x = cur_x;
        nxt_y = cur_y;
        if (off_x != '0) begin
            if (!off_x[CW]) begin
                port  = PORT_XPOS;
                chan  = cx_w;
                nxt_x = cur_x + CW'(1);
            end else begin
                port  = PORT_XNEG;
                chan  = X_TOP - cx_w;
                nxt_x = cur_x - CW'(1);
            end
        end else if (off_y != '0) begin
            if (!off_y[CW]) begin
                port  = PORT_YPOS;
                chan  = Y_BASE + cy_w;
                nxt_y = cur_y + CW'(1);
            end else begin
                port  = PORT_YNEG;
                chan  = Y_TOP - cy_w;
                nxt_y = cur_y - CW'(1);
            end
        end
    end

endmodule

// File: rtl/mdor_hold.sv
// Module: one-entry output register with a valid/ready handshake.
// Assumes the producer offers data combinationally. Takes new data when empty
// or when the current entry leaves in the same cycle.
module mdor_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);

    logic load;

    assign in_ready = !out_valid || out_ready;
    assign load     = in_valid && in_ready;

    // Occupancy flag: set on load, cleared when taken
    always_ff @(posedge clk) begin
        if (!rst_n)         out_valid <= 1'b0;
        else if (load)      out_valid <= 1'b1;
        else if (out_ready) out_valid <= 1'b0;
    end

    // Payload capture on load
    always_ff @(posedge clk) begin
        if (!rst_n)    out_data <= '0;
        else if (load) out_data <= in_data;
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)); // R9

endmodule

// File: rtl/mdor_route_unit.sv
// Module: top of the dimension-order route unit for a k-ary 2D mesh.
// Assumes node and destination coordinates lie in 0..K-1 and there is no
// wraparound. One register stage sits between the header and the result.
module mdor_route_unit
    import mdor_pkg::*;
#(
    parameter int MESH_K = 8,
    localparam int CW    = (MESH_K > 1) ? $clog2(MESH_K) : 1,
    localparam int CHW   = $clog2(2 * MESH_K + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CW-1:0]        node_x,
    input  logic [CW-1:0]        node_y,
    input  logic                 hdr_valid,
    output logic                 hdr_ready,
    input  logic [CW-1:0]        hdr_dst_x,
    input  logic [CW-1:0]        hdr_dst_y,
    output logic                 rt_valid,
    input  logic                 rt_ready,
    output logic [2:0]           rt_port,
    output logic [CHW-1:0]       rt_chan,
    output logic signed [CW:0]   rt_off_x,
    output logic signed [CW:0]   rt_off_y,
    output logic [CW-1:0]        rt_next_x,
    output logic [CW-1:0]        rt_next_y,
    output logic [CW-1:0]        rt_dst_x,
    output logic [CW-1:0]        rt_dst_y
);

    localparam int PW = 3 + CHW + 2 * (CW + 1) + 4 * CW;

    logic [1:0][CW-1:0] cur_v;
    logic [1:0][CW-1:0] dst_v;
    logic [1:0][CW:0]   off_v;
    port_e              port_c;
    logic [CHW-1:0]     chan_c;
    logic [CW-1:0]      nx_c;
    logic [CW-1:0]      ny_c;
    logic [PW-1:0]      pay_in;
    logic [PW-1:0]      pay_out;

    assign cur_v = {node_y, node_x};
    assign dst_v = {hdr_dst_y, hdr_dst_x};

    mdor_offset #(.K(MESH_K), .DIMS(2)) u_offset (
        .cur (cur_v),
        .dst (dst_v),
        .off (off_v)
    );

    mdor_decide #(.K(MESH_K)) u_decide (
        .cur_x (node_x),
        .cur_y (node_y),
        .off_x (off_v[0]),
        .off_y (off_v[1]),
        .port  (port_c),
        .chan  (chan_c),
        .nxt_x (nx_c),
        .nxt_y (ny_c)
    );

    assign pay_in = {port_c, chan_c, off_v[0], off_v[1], nx_c, ny_c,
                     hdr_dst_x, hdr_dst_y};

    mdor_hold #(.W(PW)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (hdr_valid),
        .in_ready  (hdr_ready),
        .in_data   (pay_in),
        .out_valid (rt_valid),
        .out_ready (rt_ready),
        .out_data  (pay_out)
    );

    assign {rt_port, rt_chan, rt_off_x, rt_off_y, rt_next_x, rt_next_y,
            rt_dst_x, rt_dst_y} = pay_out;

    AST_EJECT_AT_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        rt_valid && rt_port == 3'd0 |-> rt_off_x == 0 && rt_off_y == 0); // R5
    AST_Y_ONLY_AFTER_X: assert property (@(posedge clk) disable iff (!rst_n)
        rt_valid && (rt_port == 3'd3 || rt_port == 3'd4) |-> rt_off_x == 0); // R4
    AST_X_CHAN_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        rt_valid && (rt_port == 3'd1 || rt_port == 3'd2) |-> rt_chan < CHW'(MESH_K)); // R6
    AST_Y_CHAN_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        rt_valid && (rt_port == 3'd3 || rt_port == 3'd4)
        |-> rt_chan >= CHW'(MESH_K) && rt_chan < CHW'(2 * MESH_K)); // R7
    AST_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
        rt_valid && rt_port == 3'd1 |-> rt_next_x <= rt_dst_x); // R8
    AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        rt_valid && !rt_ready |-> !hdr_ready); // R9

endmodule

// File: tb/mdor_route_unit_bench.sv
module mdor_route_unit_bench;

    localparam int K   = 8;
    localparam int CW  = $clog2(K);
    localparam int CHW = $clog2(2 * K + 1);

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [CW-1:0]       node_x = '0, node_y = '0;
    logic                hdr_valid = 1'b0;
    logic                hdr_ready;
    logic [CW-1:0]       hdr_dst_x = '0, hdr_dst_y = '0;
    logic                rt_valid;
    logic                rt_ready = 1'b0;
    logic [2:0]          rt_port;
    logic [CHW-1:0]      rt_chan;
    logic signed [CW:0]  rt_off_x, rt_off_y;
    logic [CW-1:0]       rt_next_x, rt_next_y, rt_dst_x, rt_dst_y;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // model of the output register
    int mv = 0, mport = 0, mchan = 0, mox = 0, moy = 0;
    int mnx = 0, mny = 0, mdx = 0, mdy = 0;

    always #2 clk = ~clk;

    mdor_route_unit #(.MESH_K(K)) u_mdor_route_unit (
        .clk(clk), .rst_n(rst_n), .node_x(node_x), .node_y(node_y),
        .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
        .hdr_dst_x(hdr_dst_x), .hdr_dst_y(hdr_dst_y),
        .rt_valid(rt_valid), .rt_ready(rt_ready), .rt_port(rt_port),
        .rt_chan(rt_chan), .rt_off_x(rt_off_x), .rt_off_y(rt_off_y),
        .rt_next_x(rt_next_x), .rt_next_y(rt_next_y),
        .rt_dst_x(rt_dst_x), .rt_dst_y(rt_dst_y)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic string port_req(input int p);
        case (p)
            0:       return "R5";
            1, 2:    return "R3";
            default: return "R4";
        endcase
    endfunction

    // drive one cycle at a falling edge, predict, compare at next falling edge
    task automatic step(input bit v, input int dx, input int dy, input bit rdy);
        int nx, ny, ox, oy, p, c, tx, ty;
        bit acc;
        hdr_valid = v; hdr_dst_x = CW'(dx); hdr_dst_y = CW'(dy); rt_ready = rdy;
        #1;
        chk("R9 ready", int'(hdr_ready), (mv == 0 || rdy) ? 1 : 0);
        acc = v && (mv == 0 || rdy);
        if (acc) begin
            nx = int'(node_x); ny = int'(node_y);
            ox = dx - nx; oy = dy - ny; tx = nx; ty = ny;
            if (ox > 0)      begin p = 1; c = nx;           tx = nx + 1; end
            else if (ox < 0) begin p = 2; c = K - 1 - nx;   tx = nx - 1; end
            else if (oy > 0) begin p = 3; c = K + ny;       ty = ny + 1; end
            else if (oy < 0) begin p = 4; c = 2*K - 1 - ny; ty = ny - 1; end
            else             begin p = 0; c = 2*K; end
            mv = 1; mport = p; mchan = c; mox = ox; moy = oy;
            mnx = tx; mny = ty; mdx = dx; mdy = dy;
        end else if (rdy) begin
            mv = 0;
        end
        @(negedge clk);
        chk("R9 valid", int'(rt_valid), mv);
        if (mv != 0) begin
            chk(port_req(mport), int'(rt_port), mport);
            chk((mport == 0) ? "R5 chan" : (mport < 3) ? "R6" : "R7",
                int'(rt_chan), mchan);
            chk("R2 off_x", int'(rt_off_x), mox);
            chk("R2 off_y", int'(rt_off_y), moy);
            chk("R8 next_x", int'(rt_next_x), mnx);
            chk("R8 next_y", int'(rt_next_y), mny);
            chk("R2 dst", int'({rt_dst_x, rt_dst_y}), mdx * (1 << CW) + mdy);
        end
    endtask

    task automatic at_node(input int x, input int y);
        node_x = CW'(x); node_y = CW'(y);
    endtask

    // walk a whole route, feeding back the next coordinate
    task automatic walk(input int sx, input int sy, input int dx, input int dy);
        int cx = sx, cy = sy, prev = -1, hops = 0;
        for (int h = 0; h < 4 * K; h++) begin
            at_node(cx, cy);
            step(1'b1, dx, dy, 1'b1);
            chk("R10 rising chan", (int'(rt_chan) > prev) ? 1 : 0, 1);
            prev = int'(rt_chan);
            if (rt_port == 3'd0) break;
            cx = int'(rt_next_x); cy = int'(rt_next_y); hops++;
        end
        chk("R10 hops", hops,
            ((dx > sx) ? dx - sx : sx - dx) + ((dy > sy) ? dy - sy : sy - dy));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", int'(rt_valid), 0);
        chk("R1 ready in reset", int'(hdr_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", int'(rt_valid), 0);
        // directed directions and corners
        at_node(3, 4); step(1, 6, 0, 1);   // R3 +X with Y pending
        at_node(3, 4); step(1, 0, 7, 1);   // R3 -X
        at_node(3, 4); step(1, 3, 7, 1);   // R4 +Y
        at_node(3, 4); step(1, 3, 0, 1);   // R4 -Y
        at_node(3, 4); step(1, 3, 4, 1);   // R5 eject
        at_node(0, 0); step(1, 7, 7, 1);   // R6 corner
        at_node(7, 7); step(1, 0, 0, 1);   // R6 -X from top edge, chan 0
        at_node(7, 0); step(1, 7, 7, 1);   // R7 +Y from row 0
        at_node(7, 7); step(1, 7, 0, 1);   // R7 -Y from top row
        // stall: hold while not ready, and refuse a new header
        at_node(2, 2); step(1, 5, 1, 0);
        at_node(6, 6); step(1, 1, 1, 0);   // R9 ignored while full
        step(0, 0, 0, 0);
        step(0, 0, 0, 1);
        step(0, 0, 0, 1);
        // whole routes
        walk(0, 0, 7, 7);
        walk(7, 7, 0, 0);
        walk(2, 6, 5, 1);
        walk(6, 1, 1, 6);
        walk(4, 4, 4, 4);
        walk(3, 0, 3, 7);
        // random traffic with random stalls
        for (int i = 0; i < 400; i++) begin
            at_node(int'($urandom_range(K - 1)), int'($urandom_range(K - 1)));
            step(1'($urandom_range(1)), int'($urandom_range(K - 1)),
                 int'($urandom_range(K - 1)), 1'($urandom_range(1)));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule